// File: doc/BRIEF.md
# Two-Wire Configuration Register Write Slave

This block lets a host controller program a chip's configuration registers over a shared two-wire serial bus. It samples the clock and data lines with the local system clock and filters out short glitches. It then recognises start and stop conditions and collects one frame. A frame is a device address byte followed by two data bytes, which together form a 16-bit control word. The block acknowledges each accepted byte by pulling the data line low. When the last byte has been acknowledged, it hands the word to the register file as a one-cycle write strobe carrying a 7-bit register index and a 9-bit value.

The block only accepts writes. A frame carrying another device's address, or a read request, is left unanswered, and the block waits for the next start. Two device addresses are supported, and a select pin picks between them. Two register indices receive special handling. A write to index 0x17 produces a soft-reset pulse, which the register file uses to return every register to its default; this write produces no write strobe. Bit 8 of register 0x15 is a "gain pair" flag. While that flag is set, a write to either gain register (0x0E or 0x0F) is also copied to the other one.

Top module: `twcfg_two_wire_slave`

## Requirements
- R1: While reset is active and right after it, the block does not pull the data line, and neither the write strobe nor the soft-reset pulse is asserted. The gain-pair flag starts cleared.
- R2: A frame only begins on a start condition, which is a falling data edge while the clock is high. A stop condition is a rising data edge while the clock is high.
- R3: The first byte is shifted in MSB first on rising clock edges and holds a 7-bit device address followed by a direction bit, where 0 means write. The block acknowledges this byte, by pulling data low through the ninth clock, only when the address equals 0011010 with the select pin low, or 0011011 with the select pin high, and the direction bit is 0.
- R4: On an address mismatch or a direction bit of 1, the block gives no acknowledge and returns to idle. No write results, and later bytes of that frame are ignored.
- R5: The two data bytes are each acknowledged. The register index is bits 7..1 of the first data byte. The 9-bit value is the first data byte's bit 0 followed by all 8 bits of the second data byte.
- R6: A complete frame produces exactly one write strobe, one system clock wide, after the ninth clock of the second data byte ends. The register index and value are valid in the same cycle as the strobe.
- R7: A start or stop condition seen anywhere inside a frame sends the block to idle with no write. Bytes that follow, before a new start from idle, are not acknowledged.
- R8: The gain-pair flag takes bit 8 of every value written to register 0x15. While the flag is set, a write to 0x0E or 0x0F gives a second strobe in the very next cycle, with the same value and the other gain index. Writes to other registers are not duplicated.
- R9: A write to register 0x17 produces a one-cycle soft-reset pulse instead of a write strobe, and clears the gain-pair flag.
- R10: A pulse on either bus line that lasts a single system clock is ignored. It neither starts nor aborts a frame, nor does it change a received bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 1 | Selects the device address's least significant bit |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 7 | Register index for the strobe |
| wr_data_o | output | 9 | Register value for the strobe |
| soft_rst_o | output | 1 | One-cycle pulse requesting register defaults |

## Verification
Suppose the receive state machine were in the wrong state, or its bit counter were off by one. The fault would appear at the ports within a single byte time. Either the acknowledge pull would go missing or land in the wrong clock, or the strobe would carry a shifted index or value. A gain-pair flag that was left stale or cleared wrongly shows up only on the next gain write, as a second strobe appearing or missing one cycle after the first. A filter that lets glitches through turns a single-cycle pulse into a phantom start, which the bench sees as an acknowledge on a frame that should be ignored, or as a lost write within that same frame.

// File: rtl/twcfg_pkg.sv
// Shared constants and types for the two-wire configuration write slave.
package twcfg_pkg;

    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned DEV_ADDR_W   = 7;
    localparam int unsigned REG_ADDR_W   = 7;
    localparam int unsigned REG_DATA_W   = 9;
    localparam int unsigned WORD_W       = REG_ADDR_W + REG_DATA_W;
    localparam int unsigned FRAME_BYTES  = 3;

    // Base device address; the select pin replaces the LSB.
    localparam logic [DEV_ADDR_W-1:0] DEV_ADDR_BASE = 7'b0011010;

    // Register indices with behaviour inside this block.
    localparam logic [REG_ADDR_W-1:0] REG_SOFT_RESET = 7'h17;
    localparam logic [REG_ADDR_W-1:0] REG_CHAN_CTL   = 7'h15;
    localparam logic [REG_ADDR_W-1:0] REG_GAIN_L     = 7'h0E;
    localparam logic [REG_ADDR_W-1:0] REG_GAIN_R     = 7'h0F;
    localparam int unsigned           PAIR_FLAG_BIT  = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_HOLD  = 2'd2,
        PH_ACK   = 2'd3
    } phase_t;

endpackage

// File: rtl/twcfg_line_filter.sv
// Brings one asynchronous bus line into the clock domain and removes
// single-sample glitches. Assumes SYNC_STAGES >= 2 and FILT_N >= 2.
// The output only changes once FILT_N consecutive synchronized samples agree.
module twcfg_line_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_N      = 2,
    parameter logic        IDLE_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_N-1:0]      hist_q;
    logic                   level_q;

    // Metastability chain followed by the sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
            hist_q <= {FILT_N{IDLE_LEVEL}};
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            hist_q <= {hist_q[FILT_N-2:0], sync_q[SYNC_STAGES-1]};
        end
    end

    // Filtered level: follows the history only when it is unanimous.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= IDLE_LEVEL;
        end else if (&hist_q) begin
            level_q <= 1'b1;
        end else if (~|hist_q) begin
            level_q <= 1'b0;
        end
    end

    assign line_o = level_q;

endmodule

// File: rtl/twcfg_bus_events.sv
// Turns filtered clock/data levels into single-cycle bus events:
// clock edges, start (data falls, clock high) and stop (data rises, clock high).
// Assumes both inputs come from filters with equal latency.
module twcfg_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic scl_prev_q;
    logic sda_prev_q;

    // Previous-cycle levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_f;
            sda_prev_q <= sda_f;
        end
    end

    // Event decode from current and previous levels.
    always_comb begin
        scl_rise = scl_f & ~scl_prev_q;
        scl_fall = ~scl_f & scl_prev_q;
        start_ev = scl_f & scl_prev_q & sda_prev_q & ~sda_f;
        stop_ev  = scl_f & scl_prev_q & ~sda_prev_q & sda_f;
    end

endmodule

// File: rtl/twcfg_frame_rx.sv
// Frame receiver: shifts in the address byte and two data bytes, decides
// whether to acknowledge, drives the acknowledge pull and reports a
// complete 16-bit word. A start or stop inside a frame aborts to idle.
module twcfg_frame_rx
    import twcfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_ev,
    input  logic                  stop_ev,
    input  logic                  sda_bit,
    input  logic [DEV_ADDR_W-1:0] dev_addr,
    output logic                  ack_pull,
    output logic                  frame_done,
    output logic [WORD_W-1:0]     frame_word,
    output phase_t                phase
);

    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam int unsigned IDX_W = $clog2(FRAME_BYTES);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(FRAME_BYTES - 1);

    phase_t              phase_q;
    logic [CNT_W-1:0]    bit_cnt_q;
    logic [IDX_W-1:0]    byte_idx_q;
    logic [BYTE_W-1:0]   shreg_q;
    logic [BYTE_W-1:0]   hi_byte_q;
    logic [BYTE_W-1:0]   lo_byte_q;
    logic                ack_q;
    logic                done_q;
    logic                addr_ok;

    // Address byte accepted: matching device and write direction.
    assign addr_ok = (shreg_q[BYTE_W-1:1] == dev_addr) && !shreg_q[0];

    // Frame sequencing: phase, counters, shift register and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            bit_cnt_q  <= '0;
            byte_idx_q <= '0;
            shreg_q    <= '0;
            hi_byte_q  <= '0;
            lo_byte_q  <= '0;
            ack_q      <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_ev || stop_ev) begin
                ack_q <= 1'b0;
                if (phase_q != PH_IDLE) begin
                    phase_q <= PH_IDLE;
                end else if (start_ev) begin
                    phase_q    <= PH_SHIFT;
                    bit_cnt_q  <= '0;
                    byte_idx_q <= '0;
                end
            end else begin
                unique case (phase_q)
                    PH_IDLE: begin
                        ack_q <= 1'b0;
                    end
                    PH_SHIFT: begin
                        if (scl_rise) begin
                            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_bit};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            if (bit_cnt_q == LAST_BIT) begin
                                phase_q <= PH_HOLD;
                            end
                        end
                    end
                    PH_HOLD: begin
                        if (scl_fall) begin
                            if (byte_idx_q == '0) begin
                                if (addr_ok) begin
                                    phase_q <= PH_ACK;
                                    ack_q   <= 1'b1;
                                end else begin
                                    phase_q <= PH_IDLE;
                                end
                            end else begin
                                if (byte_idx_q == LAST_BYTE) begin
                                    lo_byte_q <= shreg_q;
                                end else begin
                                    hi_byte_q <= shreg_q;
                                end
                                phase_q <= PH_ACK;
                                ack_q   <= 1'b1;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            ack_q <= 1'b0;
                            if (byte_idx_q == LAST_BYTE) begin
                                done_q  <= 1'b1;
                                phase_q <= PH_IDLE;
                            end else begin
                                byte_idx_q <= byte_idx_q + 1'b1;
                                bit_cnt_q  <= '0;
                                phase_q    <= PH_SHIFT;
                            end
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign ack_pull   = ack_q;
    assign frame_done = done_q;
    assign frame_word = {hi_byte_q, lo_byte_q};
    assign phase      = phase_q;

endmodule

// File: rtl/twcfg_write_issue.sv
// Converts a received control word into register-side actions: a write
// strobe, a duplicated strobe for the gain pair while the pair flag is set,
// or a soft-reset pulse. Holds the pair flag itself.
module twcfg_write_issue
    import twcfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_done,
    input  logic [WORD_W-1:0]     frame_word,
    output logic                  wr_stb,
    output logic [REG_ADDR_W-1:0] wr_addr,
    output logic [REG_DATA_W-1:0] wr_data,
    output logic                  soft_rst,
    output logic                  pair_en
);

    logic [REG_ADDR_W-1:0] idx;
    logic [REG_DATA_W-1:0] val;
    logic                  is_gain;
    logic                  pair_q;
    logic                  pend_q;
    logic [REG_ADDR_W-1:0] pend_addr_q;
    logic                  stb_q;
    logic                  srst_q;
    logic [REG_ADDR_W-1:0] addr_q;
    logic [REG_DATA_W-1:0] data_q;

    // Word split and gain-register decode.
    always_comb begin
        idx     = frame_word[WORD_W-1:REG_DATA_W];
        val     = frame_word[REG_DATA_W-1:0];
        is_gain = (idx == REG_GAIN_L) || (idx == REG_GAIN_R);
    end

    // Strobe, pair duplication, soft reset and pair flag upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q      <= 1'b0;
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            stb_q       <= 1'b0;
            srst_q      <= 1'b0;
            addr_q      <= '0;
            data_q      <= '0;
        end else begin
            stb_q  <= 1'b0;
            srst_q <= 1'b0;
            pend_q <= 1'b0;
            if (frame_done) begin
                if (idx == REG_SOFT_RESET) begin
                    srst_q <= 1'b1;
                    pair_q <= 1'b0;
                end else begin
                    stb_q  <= 1'b1;
                    addr_q <= idx;
                    data_q <= val;
                    if (idx == REG_CHAN_CTL) begin
                        pair_q <= val[PAIR_FLAG_BIT];
                    end
                    if (is_gain && pair_q) begin
                        pend_q      <= 1'b1;
                        pend_addr_q <= (idx == REG_GAIN_L) ? REG_GAIN_R : REG_GAIN_L;
                    end
                end
            end else if (pend_q) begin
                stb_q  <= 1'b1;
                addr_q <= pend_addr_q;
            end
        end
    end

    assign wr_stb   = stb_q;
    assign wr_addr  = addr_q;
    assign wr_data  = data_q;
    assign soft_rst = srst_q;
    assign pair_en  = pair_q;

endmodule

// File: rtl/twcfg_two_wire_slave.sv
// Top of the write-only two-wire configuration slave. Filters both bus
// lines, decodes bus events, receives frames and issues register writes.
// Assumes an external open-drain pad: sda_pull_o = 1 drives the line low.
module twcfg_two_wire_slave
    import twcfg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned GLITCH_SAMPLES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic                  addr_sel_i,
    output logic                  sda_pull_o,
    output logic                  wr_stb_o,
    output logic [REG_ADDR_W-1:0] wr_addr_o,
    output logic [REG_DATA_W-1:0] wr_data_o,
    output logic                  soft_rst_o
);

    localparam int unsigned N_LINES = 2;  // index 1 = clock, 0 = data

    logic [N_LINES-1:0]    raw_lines;
    logic [N_LINES-1:0]    filt_lines;
    logic                  scl_f;
    logic                  sda_f;
    logic                  scl_rise;
    logic                  scl_fall;
    logic                  start_ev;
    logic                  stop_ev;
    logic [DEV_ADDR_W-1:0] dev_addr;
    logic                  frame_done;
    logic [WORD_W-1:0]     frame_word;
    phase_t                phase_w;
    logic                  pair_en;

    assign raw_lines = {scl_i, sda_i};
    assign scl_f     = filt_lines[1];
    assign sda_f     = filt_lines[0];
    assign dev_addr  = {DEV_ADDR_BASE[DEV_ADDR_W-1:1], addr_sel_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        twcfg_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_N      (GLITCH_SAMPLES),
            .IDLE_LEVEL  (1'b1)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    twcfg_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    twcfg_frame_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .sda_bit    (sda_f),
        .dev_addr   (dev_addr),
        .ack_pull   (sda_pull_o),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .phase      (phase_w)
    );

    twcfg_write_issue u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .wr_stb     (wr_stb_o),
        .wr_addr    (wr_addr_o),
        .wr_data    (wr_data_o),
        .soft_rst   (soft_rst_o),
        .pair_en    (pair_en)
    );

endmodule

// File: rtl/twcfg_two_wire_slave_chk.sv
// Property checker for the two-wire configuration slave, bound to the top.
module twcfg_two_wire_slave_chk
    import twcfg_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_f,
    input logic                  start_ev,
    input logic                  stop_ev,
    input phase_t                phase,
    input logic                  frame_done,
    input logic [WORD_W-1:0]     frame_word,
    input logic                  pair_en,
    input logic                  sda_pull,
    input logic                  wr_stb,
    input logic [REG_DATA_W-1:0] wr_data,
    input logic                  soft_rst
);

    AST_STB_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(frame_done) || $past(wr_stb))); // R6

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_ev || stop_ev) && phase != PH_IDLE) |=> (phase == PH_IDLE)); // R7

    AST_NO_PULL_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_pull); // R4

    AST_PULL_MOVES_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull) && !$past(start_ev || stop_ev)) |-> !scl_f); // R3

    AST_PAIR_SECOND_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && pair_en && frame_word[WORD_W-1:REG_DATA_W+1] == REG_GAIN_L[REG_ADDR_W-1:1])
        |=> wr_stb ##1 (wr_stb && wr_data == $past(wr_data))); // R8

    AST_SOFT_NOT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(soft_rst && wr_stb)); // R9

    AST_SOFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst); // R9

endmodule

bind twcfg_two_wire_slave twcfg_two_wire_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f      (scl_f),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .phase      (phase_w),
    .frame_done (frame_done),
    .frame_word (frame_word),
    .pair_en    (pair_en),
    .sda_pull   (sda_pull_o),
    .wr_stb     (wr_stb_o),
    .wr_data    (wr_data_o),
    .soft_rst   (soft_rst_o)
);

// File: tb/sim_twcfg_two_wire_slave.sv
// Directed bench for the two-wire configuration slave.
module sim_twcfg_two_wire_slave;

    localparam int Q    = 10;   // system clocks per bus half period
    localparam int HALF = Q / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic       sda_pull;
    logic       wr_stb;
    logic [6:0] wr_addr;
    logic [8:0] wr_data;
    logic       soft_rst;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    twcfg_two_wire_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .addr_sel_i (addr_sel),
        .sda_pull_o (sda_pull),
        .wr_stb_o   (wr_stb),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .soft_rst_o (soft_rst)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Event log of strobes and soft-reset pulses, sampled away from the edge.
    int         cyc = 0;
    int         n_ev = 0;
    int         n_soft = 0;
    logic [6:0] ev_addr [8];
    logic [8:0] ev_data [8];
    int         ev_cyc  [8];

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (wr_stb) begin
                if (n_ev < 8) begin
                    ev_addr[n_ev] = wr_addr;
                    ev_data[n_ev] = wr_data;
                    ev_cyc[n_ev]  = cyc;
                end
                n_ev = n_ev + 1;
            end
            if (soft_rst) n_soft = n_soft + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        n_ev = 0;
        n_soft = 0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    // One data bit; optional one-cycle inversion in the middle of clock high.
    task automatic bus_bit(input logic b, input bit glitch);
        sda_m = b; wait_clk(HALF);
        scl_m = 1'b1;
        if (glitch) begin
            wait_clk(3); sda_m = ~b; wait_clk(1); sda_m = b; wait_clk(Q - 4);
        end else begin
            wait_clk(Q);
        end
        scl_m = 1'b0; wait_clk(HALF);
    endtask

    // Eight bits MSB first plus the acknowledge slot; glitch_at selects a bit.
    task automatic bus_byte(input logic [7:0] b, input int glitch_at, output logic acked);
        for (int i = 7; i >= 0; i--) bus_bit(b[i], glitch_at == i);
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        acked = sda_pull;
        wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF);
    endtask

    task automatic bus_write(input logic [6:0] dev, input logic rw, input logic [6:0] idx,
                             input logic [8:0] val, output logic [2:0] acks);
        logic a;
        bus_start();
        bus_byte({dev, rw}, -1, a);              acks[2] = a;
        bus_byte({idx, val[8]}, -1, a);          acks[1] = a;
        bus_byte(val[7:0], -1, a);               acks[0] = a;
        bus_stop();
        wait_clk(12);
    endtask

    task automatic t_reset();
        check(sda_pull == 1'b0, "R1 pull in reset", sda_pull, 0);
        check(wr_stb == 1'b0 && soft_rst == 1'b0, "R1 pulses in reset", {wr_stb, soft_rst}, 0);
        wait_clk(2); rst_n = 1'b1; wait_clk(4);
        check(sda_pull == 1'b0 && wr_stb == 1'b0 && soft_rst == 1'b0, "R1 after reset",
              {sda_pull, wr_stb, soft_rst}, 0);
    endtask

    task automatic t_basic();
        logic [2:0] acks;
        addr_sel = 1'b0; clear_log();
        bus_write(7'b0011010, 1'b0, 7'h0C, 9'h122, acks);
        check(acks == 3'b111, "R3 R5 acks", acks, 3'b111);
        check(n_ev == 1, "R6 one strobe", n_ev, 1);
        check(ev_addr[0] == 7'h0C && ev_data[0] == 9'h122, "R5 word split",
              {ev_addr[0], ev_data[0]}, {7'h0C, 9'h122});
        clear_log();
        bus_write(7'b0011010, 1'b0, 7'h0B, 9'h0FF, acks);
        check(n_ev == 1 && ev_addr[0] == 7'h0B && ev_data[0] == 9'h0FF, "R5 data bit8 low",
              {ev_addr[0], ev_data[0]}, {7'h0B, 9'h0FF});
    endtask

    task automatic t_select();
        logic [2:0] acks;
        addr_sel = 1'b1; clear_log();
        bus_write(7'b0011011, 1'b0, 7'h0D, 9'h040, acks);
        check(acks == 3'b111 && n_ev == 1, "R3 select high address", {acks, 4'(n_ev)}, {3'b111, 4'd1});
        clear_log();
        bus_write(7'b0011010, 1'b0, 7'h0D, 9'h041, acks);
        check(acks == 3'b000, "R4 other address no ack", acks, 0);
        check(n_ev == 0, "R4 other address no write", n_ev, 0);
        addr_sel = 1'b0;
    endtask

    task automatic t_read();
        logic [2:0] acks;
        clear_log();
        bus_write(7'b0011010, 1'b1, 7'h0C, 9'h1AA, acks);
        check(acks == 3'b000, "R4 read not acked", acks, 0);
        check(n_ev == 0, "R4 read no write", n_ev, 0);
    endtask

    task automatic t_abort();
        logic a;
        logic [2:0] acks;
        clear_log();
        bus_start();
        bus_byte(8'b00110100, -1, a);
        bus_byte({7'h10, 1'b0}, -1, a);
        for (int i = 0; i < 4; i++) bus_bit(1'b1, 1'b0);
        bus_stop(); wait_clk(12);
        check(n_ev == 0, "R7 stop mid frame", n_ev, 0);
        bus_start();
        bus_byte(8'b00110100, -1, a);
        bus_byte({7'h10, 1'b1}, -1, a);
        bus_start();
        bus_byte(8'h5A, -1, a);
        check(a == 1'b0, "R7 byte after mid-frame start", a, 0);
        bus_stop(); wait_clk(12);
        check(n_ev == 0, "R7 start mid frame", n_ev, 0);
        bus_write(7'b0011010, 1'b0, 7'h10, 9'h07B, acks);
        check(n_ev == 1 && ev_data[0] == 9'h07B, "R2 new frame after abort", ev_data[0], 9'h07B);
    endtask

    task automatic t_pair();
        logic [2:0] acks;
        clear_log();
        bus_write(7'b0011010, 1'b0, 7'h15, 9'h101, acks);
        check(n_ev == 1 && ev_addr[0] == 7'h15, "R8 flag write strobes once", n_ev, 1);
        clear_log();
        bus_write(7'b0011010, 1'b0, 7'h0E, 9'h0AB, acks);
        check(n_ev == 2, "R8 left gain pair count", n_ev, 2);
        check(ev_addr[0] == 7'h0E && ev_addr[1] == 7'h0F, "R8 left then right",
              {ev_addr[0], ev_addr[1]}, {7'h0E, 7'h0F});
        check(ev_data[1] == 9'h0AB && ev_cyc[1] == ev_cyc[0] + 1, "R8 same data next cycle",
              ev_cyc[1] - ev_cyc[0], 1);
        clear_log();
        bus_write(7'b0011010, 1'b0, 7'h0F, 9'h055, acks);
        check(n_ev == 2 && ev_addr[0] == 7'h0F && ev_addr[1] == 7'h0E && ev_data[1] == 9'h055,
              "R8 right then left", {ev_addr[0], ev_addr[1]}, {7'h0F, 7'h0E});
        clear_log();
        bus_write(7'b0011010, 1'b0, 7'h10, 9'h033, acks);
        check(n_ev == 1, "R8 non-gain not paired", n_ev, 1);
        clear_log();
        bus_write(7'b0011010, 1'b0, 7'h15, 9'h001, acks);
        bus_write(7'b0011010, 1'b0, 7'h0E, 9'h0C0, acks);
        check(n_ev == 2, "R8 flag cleared single gain strobe", n_ev, 2);
    endtask

    task automatic t_soft();
        logic [2:0] acks;
        bus_write(7'b0011010, 1'b0, 7'h15, 9'h100, acks);
        clear_log();
        bus_write(7'b0011010, 1'b0, 7'h17, 9'h000, acks);
        check(n_soft == 1, "R9 soft reset pulse", n_soft, 1);
        check(n_ev == 0, "R9 no strobe for soft reset", n_ev, 0);
        bus_write(7'b0011010, 1'b0, 7'h0E, 9'h011, acks);
        check(n_ev == 1, "R9 pair flag cleared", n_ev, 1);
    endtask

    task automatic t_glitch();
        logic a;
        clear_log();
        sda_m = 1'b0; wait_clk(1); sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b0; wait_clk(HALF);
        bus_byte(8'b00110100, -1, a);
        check(a == 1'b0, "R10 data glitch no false start", a, 0);
        bus_stop(); wait_clk(12);
        bus_start();
        bus_byte(8'b00110100, 5, a);
        bus_byte({7'h0C, 1'b1}, 3, a);
        bus_byte(8'h96, 0, a);
        check(a == 1'b1, "R10 glitches inside frame", a, 1);
        bus_stop(); wait_clk(12);
        check(n_ev == 1 && ev_addr[0] == 7'h0C && ev_data[0] == 9'h196, "R10 word intact",
              {ev_addr[0], ev_data[0]}, {7'h0C, 9'h196});
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        wait_clk(3);
        t_reset();
        t_basic();
        t_select();
        t_read();
        t_abort();
        t_pair();
        t_soft();
        t_glitch();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

endmodule